// File: doc/BRIEF.md
# Linked-Order Serial Result Sequencer

This block sends a chain of 16-bit result words out of a three-wire serial port: a bit clock, a data line and a frame sync line. Seven word types can appear in a chain: in-phase (I), quadrature (Q), magnitude, phase, frequency, AGC level and timing error. A chain always opens with the I word. Each word type has its own 3-bit link value that names the word sent after it. Software therefore sets the output order, and the length of the chain, by writing the links.

A single-cycle start strobe, accepted only while the port is idle, latches all seven word values and the whole configuration. The block then shifts the chain out MSB first with no gap bits between words. The bit clock is a divided copy of the processing clock, and its phase relative to data changes can be selected. A one-bit-time sync pulse marks each word boundary, placed either just ahead of a word or just behind it, with a selectable level. The LSB of the I word can be forced to a tag value.

Top module: `sqo_linked_serial`

## Requirements
- R1: A start strobe seen while the port is idle begins a chain whose first word is always I. The link after I comes from `link_after_i`. Word codes are 000=I, 001=Q, 010=magnitude, 011=phase, 100=frequency, 101=AGC, 110=timing error and 111=end of chain.
- R2: The word after each non-I word is chosen by its 3-bit field in `link_tbl`: [17:15] after Q, [14:12] after magnitude, [11:9] after phase, [8:6] after frequency, [5:3] after AGC and [2:0] after timing error. The same code can be chosen again, so words can repeat.
- R3: The chain ends after a word whose link is 111 has been sent, or after the seventh word, whichever comes first.
- R4: `rate_sel` sets the bit time in processing-clock cycles: 000 gives 16, 001 gives 8, 010 gives 4, 011 gives 2, and any 1xx value gives 1.
- R5: With `clk_pol`=1, `ser_clk` is low in the first half of each bit time and high in the second half, so data changes on its falling edge. With `clk_pol`=0 the halves are swapped, so data changes on its rising edge. At a bit time of 1 cycle, `ser_clk` holds the first-half level for the whole chain. When idle, `ser_clk` rests at the `clk_pol` level.
- R6: `ser_sync` equals the internal pulse XOR `sync_inv`. A value of 0 gives an active-high pulse and 1 gives an active-low pulse. The inactive level is held while idle.
- R7: The sync pulse lasts exactly one bit time. With `sync_early`=1 it covers the bit time just before the first bit of every word, so a lead bit time with data 0 opens the chain. With `sync_early`=0 it covers the bit time just after the last bit of every word, so a trail bit time with data 0 closes the chain.
- R8: `tag_mode` sets the I word LSB: 00 passes it through, 01 forces 0, and 1x forces 1. Other words are never altered.
- R9: Every word is 16 bits, sent MSB first. Consecutive words follow each other with no idle bit times between them.
- R10: Word values are captured on the accepted start strobe. Changes on the word inputs during a chain do not affect it.
- R11: A start strobe during a chain is ignored. Configuration inputs are sampled only at an accepted start, and a new value takes effect at the next accepted start.
- R12: Synchronous active-high reset returns the port to idle with `ser_clk`, `ser_data` and `ser_sync` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that begins a chain |
| i_word | input | 16 | In-phase result |
| q_word | input | 16 | Quadrature result |
| mag_word | input | 16 | Magnitude result |
| phs_word | input | 16 | Phase result |
| frq_word | input | 16 | Frequency result |
| agc_word | input | 16 | AGC level result |
| ter_word | input | 16 | Timing error result |
| link_after_i | input | 3 | Code of the word sent after I |
| link_tbl | input | 18 | Packed next-word codes for the other six words |
| rate_sel | input | 3 | Bit time selection |
| sync_inv | input | 1 | Sync level select (1 = active low) |
| clk_pol | input | 1 | Bit clock phase select |
| sync_early | input | 1 | Sync placement (1 = before word, 0 = after word) |
| tag_mode | input | 2 | I word LSB override |
| ser_clk | output | 1 | Serial bit clock |
| ser_data | output | 1 | Serial data, MSB first |
| ser_sync | output | 1 | Word sync pulse |

## Verification
The assertions assume that `start` and every configuration and word input are synchronous to `clk` and stable around its rising edge. They place no limit on link values: any code, including loops that point back to an earlier word, must end safely through the seven-word cap. The stimulus drives every input on the falling edge. It changes words, links, rate and polarity only before a start, or on purpose in the middle of a chain to show that those changes are ignored. The stimulus also raises `start` during a chain to exercise the rule that such a strobe is dropped.

// File: rtl/sqo_pkg.sv
`timescale 1ns/1ps
package sqo_pkg;

  localparam int LINK_W   = 3;
  localparam int NLINKED  = 6;                 // word types with a table link
  localparam int TBL_W    = NLINKED * LINK_W;
  localparam int RATE_W   = 3;
  localparam int PH_W     = 4;                 // holds the slowest bit time - 1
  localparam int PER_W    = PH_W + 1;

  localparam logic [LINK_W-1:0] SEL_I   = 3'd0;
  localparam logic [LINK_W-1:0] SEL_Q   = 3'd1;
  localparam logic [LINK_W-1:0] SEL_MAG = 3'd2;
  localparam logic [LINK_W-1:0] SEL_PHS = 3'd3;
  localparam logic [LINK_W-1:0] SEL_FRQ = 3'd4;
  localparam logic [LINK_W-1:0] SEL_AGC = 3'd5;
  localparam logic [LINK_W-1:0] SEL_TER = 3'd6;
  localparam logic [LINK_W-1:0] SEL_END = 3'd7;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_WORD, ST_TRAIL} seq_st_e;

  typedef struct packed {
    logic [LINK_W-1:0] link_i;
    logic [TBL_W-1:0]  link_tbl;
    logic [RATE_W-1:0] rate;
    logic              sync_inv;
    logic              clk_pol;
    logic              sync_early;
    logic [1:0]        tag;
  } cfg_t;

  // Bit time in processing-clock cycles.
  function automatic logic [PER_W-1:0] period_of(input logic [RATE_W-1:0] r);
    logic [PER_W-1:0] full;
    full = PER_W'(1) << PH_W;
    if (r[2]) return PER_W'(1);
    return full >> r[1:0];
  endfunction

  // Code of the word that follows word s.
  function automatic logic [LINK_W-1:0] next_of(input logic [LINK_W-1:0] s,
                                                input logic [LINK_W-1:0] li,
                                                input logic [TBL_W-1:0]  tbl);
    case (s)
      SEL_I:   return li;
      SEL_Q:   return tbl[17:15];
      SEL_MAG: return tbl[14:12];
      SEL_PHS: return tbl[11:9];
      SEL_FRQ: return tbl[8:6];
      SEL_AGC: return tbl[5:3];
      SEL_TER: return tbl[2:0];
      default: return SEL_END;
    endcase
  endfunction

endpackage

// File: rtl/sqo_bit_timer.sv
`timescale 1ns/1ps
module sqo_bit_timer
  import sqo_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              bit_last,
  output logic              first_half
);

  logic [PER_W-1:0] period;
  logic [PH_W-1:0]  ph;

  assign period     = period_of(rate);
  assign bit_last   = ({1'b0, ph} == period - PER_W'(1));
  assign first_half = (period == PER_W'(1)) || ({1'b0, ph} < (period >> 1));

  always_ff @(posedge clk) begin
    if (rst || load) begin
      ph <= '0;
    end else if (run) begin
      ph <= bit_last ? '0 : ph + 1'b1;
    end
  end

  // R4: the phase counter never leaves the selected bit time
  a_r4_phase_in_period: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, ph} < period));

endmodule

// File: rtl/sqo_word_store.sv
`timescale 1ns/1ps
module sqo_word_store
  import sqo_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NWORD  = 7
)(
  input  logic                    clk,
  input  logic                    load,
  input  logic [1:0]              tag,
  input  logic [NWORD*WORD_W-1:0] words_in,
  input  logic [LINK_W-1:0]       rd_sel,
  output logic [WORD_W-1:0]       rd_word
);

  logic [WORD_W-1:0] mem [0:NWORD-1];

  generate
    for (genvar g = 0; g < NWORD; g++) begin : g_entry
      logic [WORD_W-1:0] wv;
      if (g == 0) begin : g_tagged
        // entry 0 is the I word: its LSB may be overridden
        always_comb begin
          wv = words_in[WORD_W-1:0];
          if (tag[1])      wv[0] = 1'b1;
          else if (tag[0]) wv[0] = 1'b0;
        end
      end else begin : g_plain
        assign wv = words_in[g*WORD_W +: WORD_W];
      end
      always_ff @(posedge clk) begin
        if (load) mem[g] <= wv;
      end
    end
  endgenerate

  assign rd_word = (rd_sel < LINK_W'(NWORD)) ? mem[rd_sel] : '0;

endmodule

// File: rtl/sqo_chain_ctrl.sv
`timescale 1ns/1ps
module sqo_chain_ctrl
  import sqo_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 7
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [LINK_W-1:0]   link_i,
  input  logic [TBL_W-1:0]    link_tbl,
  input  logic                sync_early,
  input  logic                bit_last,
  output logic                accept,
  output seq_st_e             st,
  output logic [LINK_W-1:0]   sel,
  output logic [$clog2(WORD_W)-1:0] bit_idx,
  output logic                sync_act
);

  localparam int BIT_W = $clog2(WORD_W);
  localparam int CNT_W = $clog2(MAX_WORDS + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(MAX_WORDS);

  logic [CNT_W-1:0]  wcnt;
  logic              last_w;
  logic [LINK_W-1:0] nxt;
  logic [LINK_W-1:0] nxt_of_nxt;
  logic [LINK_W-1:0] nxt_of_i;

  assign accept     = start && (st == ST_IDLE);
  assign nxt        = next_of(sel, link_i, link_tbl);
  assign nxt_of_nxt = next_of(nxt, link_i, link_tbl);
  assign nxt_of_i   = next_of(SEL_I, link_i, link_tbl);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      sel     <= SEL_I;
      bit_idx <= '0;
      wcnt    <= '0;
      last_w  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            st      <= sync_early ? ST_LEAD : ST_WORD;
            sel     <= SEL_I;
            bit_idx <= '0;
            wcnt    <= CNT_W'(1);
            last_w  <= (nxt_of_i == SEL_END) || (CNT_CAP == CNT_W'(1));
          end
        end
        ST_LEAD: begin
          if (bit_last) st <= ST_WORD;
        end
        ST_WORD: begin
          if (bit_last) begin
            if (bit_idx == LAST_BIT) begin
              bit_idx <= '0;
              if (last_w) begin
                st <= sync_early ? ST_IDLE : ST_TRAIL;
              end else begin
                sel    <= nxt;
                wcnt   <= wcnt + 1'b1;
                last_w <= (nxt_of_nxt == SEL_END) || (wcnt + 1'b1 == CNT_CAP);
              end
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        ST_TRAIL: begin
          if (bit_last) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (sync_early)
      sync_act = (st == ST_LEAD) || (st == ST_WORD && bit_idx == LAST_BIT && !last_w);
    else
      sync_act = (st == ST_TRAIL) || (st == ST_WORD && bit_idx == '0 && wcnt > CNT_W'(1));
  end

  // R3: a running chain never counts past the word cap
  a_r3_count_cap: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |-> (wcnt != '0 && wcnt <= CNT_CAP));

  // R3: the end of the final word in early mode returns the port to idle
  a_r3_stop_after_last: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WORD && bit_last && bit_idx == LAST_BIT && last_w && sync_early)
      |=> (st == ST_IDLE));

  // R1: an accepted start opens the chain with the I word
  a_r1_first_is_i: assert property (@(posedge clk) disable iff (rst)
    accept |=> (sel == SEL_I && wcnt == CNT_W'(1) && st != ST_IDLE));

  // R11: a start strobe in the middle of a word leaves the chain untouched
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WORD && start && !bit_last) |=> ($stable(sel) && $stable(wcnt)));

endmodule

// File: rtl/sqo_linked_serial.sv
`timescale 1ns/1ps
module sqo_linked_serial
  import sqo_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 7
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] i_word,
  input  logic [WORD_W-1:0] q_word,
  input  logic [WORD_W-1:0] mag_word,
  input  logic [WORD_W-1:0] phs_word,
  input  logic [WORD_W-1:0] frq_word,
  input  logic [WORD_W-1:0] agc_word,
  input  logic [WORD_W-1:0] ter_word,
  input  logic [2:0]        link_after_i,
  input  logic [17:0]       link_tbl,
  input  logic [2:0]        rate_sel,
  input  logic              sync_inv,
  input  logic              clk_pol,
  input  logic              sync_early,
  input  logic [1:0]        tag_mode,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_sync
);

  localparam int NWORD = 7;
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(WORD_W - 1);

  cfg_t cfg_in, cfg_q, cfg_use;
  logic accept, bit_last, first_half, sync_act;
  seq_st_e st;
  logic [LINK_W-1:0] sel;
  logic [BIT_W-1:0]  bit_idx;
  logic [WORD_W-1:0] rd_word;
  logic clk_q, data_q, sync_q;

  assign cfg_in = '{link_i: link_after_i, link_tbl: link_tbl, rate: rate_sel,
                    sync_inv: sync_inv, clk_pol: clk_pol,
                    sync_early: sync_early, tag: tag_mode};
  assign cfg_use = accept ? cfg_in : cfg_q;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (accept) cfg_q <= cfg_in;
  end

  sqo_chain_ctrl #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .link_i(cfg_use.link_i), .link_tbl(cfg_use.link_tbl),
    .sync_early(cfg_use.sync_early), .bit_last(bit_last),
    .accept(accept), .st(st), .sel(sel), .bit_idx(bit_idx), .sync_act(sync_act)
  );

  sqo_bit_timer u_timer (
    .clk(clk), .rst(rst), .load(accept), .run(st != ST_IDLE),
    .rate(cfg_use.rate), .bit_last(bit_last), .first_half(first_half)
  );

  sqo_word_store #(.WORD_W(WORD_W), .NWORD(NWORD)) u_store (
    .clk(clk), .load(accept), .tag(cfg_use.tag),
    .words_in({ter_word, agc_word, frq_word, phs_word, mag_word, q_word, i_word}),
    .rd_sel(sel), .rd_word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q  <= 1'b0;
      data_q <= 1'b0;
      sync_q <= 1'b0;
    end else if (st == ST_IDLE) begin
      clk_q  <= cfg_q.clk_pol;
      data_q <= 1'b0;
      sync_q <= cfg_q.sync_inv;
    end else begin
      clk_q  <= first_half ? ~cfg_q.clk_pol : cfg_q.clk_pol;
      data_q <= (st == ST_WORD) ? rd_word[TOP_BIT - bit_idx] : 1'b0;
      sync_q <= sync_act ^ cfg_q.sync_inv;
    end
  end

  assign ser_clk  = clk_q;
  assign ser_data = data_q;
  assign ser_sync = sync_q;

  // R11: the captured configuration stays put while a chain runs
  a_r11_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && $past(st != ST_IDLE)) |-> $stable(cfg_q));

  // R5: an idle port rests the bit clock at the selected polarity level
  a_r5_idle_clk_level: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && $past(st == ST_IDLE)) |-> (ser_clk == cfg_q.clk_pol));

  // R6: an idle port holds sync at its inactive level and data low
  a_r6_idle_sync_level: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && $past(st == ST_IDLE)) |-> (ser_sync == cfg_q.sync_inv && !ser_data));

endmodule

// File: tb/sqo_linked_serial_bench.sv
`timescale 1ns/1ps
module sqo_linked_serial_bench;

  localparam int W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic rst, start;
  logic [W-1:0] i_word, q_word, mag_word, phs_word, frq_word, agc_word, ter_word;
  logic [2:0]  link_after_i, rate_sel;
  logic [17:0] link_tbl;
  logic sync_inv, clk_pol, sync_early;
  logic [1:0] tag_mode;
  logic ser_clk, ser_data, ser_sync;

  sqo_linked_serial u_sqo_linked_serial (
    .clk(clk), .rst(rst), .start(start),
    .i_word(i_word), .q_word(q_word), .mag_word(mag_word), .phs_word(phs_word),
    .frq_word(frq_word), .agc_word(agc_word), .ter_word(ter_word),
    .link_after_i(link_after_i), .link_tbl(link_tbl), .rate_sel(rate_sel),
    .sync_inv(sync_inv), .clk_pol(clk_pol), .sync_early(sync_early),
    .tag_mode(tag_mode), .ser_clk(ser_clk), .ser_data(ser_data), .ser_sync(ser_sync)
  );

  typedef struct packed { logic c; logic d; logic s; } oval_t;

  oval_t mq[$];
  oval_t exp_o = '0;
  logic  m_pol = 1'b0, m_inv = 1'b0;
  int    n_checks = 0, n_fail = 0;
  bit    compare_on = 1'b0;
  string case_tag = "R12 reset";

  function automatic int m_link(input int s);
    if (s == 0) return int'(link_after_i);
    return int'(link_tbl[3*(6-s) + 2 -: 3]);
  endfunction

  // Behavioural model: list every cycle of the chain as a queue entry.
  task automatic build_chain();
    int p, nl, nw, s;
    logic [W-1:0] w [7];
    int seq[$];
    logic [1:0] slots[$];
    p = rate_sel[2] ? 1 : (16 >> rate_sel[1:0]);
    w[0] = i_word;
    if (tag_mode[1]) w[0][0] = 1'b1;
    else if (tag_mode[0]) w[0][0] = 1'b0;
    w[1] = q_word; w[2] = mag_word; w[3] = phs_word;
    w[4] = frq_word; w[5] = agc_word; w[6] = ter_word;
    s = 0;
    for (int k = 1; k <= 7; k++) begin
      seq.push_back(s);
      nl = m_link(s);
      if (nl == 7 || k == 7) break;
      s = nl;
    end
    nw = seq.size();
    if (sync_early) slots.push_back(2'b01);
    for (int k = 0; k < nw; k++) begin
      for (int b = 0; b < W; b++) begin
        logic dd, ss;
        dd = w[seq[k]][W-1-b];
        ss = sync_early ? (b == W-1 && k < nw-1) : (b == 0 && k > 0);
        slots.push_back({dd, ss});
      end
    end
    if (!sync_early) slots.push_back(2'b01);
    m_pol = clk_pol;
    m_inv = sync_inv;
    foreach (slots[j]) begin
      for (int ph = 0; ph < p; ph++) begin
        oval_t o;
        o.c = (p == 1 || ph < p/2) ? ~clk_pol : clk_pol;
        o.d = slots[j][1];
        o.s = slots[j][0] ^ sync_inv;
        mq.push_back(o);
      end
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      exp_o <= '0;
      m_pol = 1'b0;
      m_inv = 1'b0;
    end else if (mq.size() > 0) begin
      exp_o <= mq.pop_front();
    end else begin
      exp_o <= {m_pol, 1'b0, m_inv};
      if (start) build_chain();
    end
    compare_on <= 1'b1;
  end

  task automatic check1(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s [%s] at %0t: actual %0b expected %0b", req, what, case_tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on) begin
      check1("R5", "ser_clk",  ser_clk,  exp_o.c);
      check1("R9", "ser_data", ser_data, exp_o.d);
      check1("R7", "ser_sync", ser_sync, exp_o.s);
    end
  end

  task automatic kick();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (mq.size() != 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic set_words(input logic [W-1:0] base);
    i_word = base ^ 16'h8001; q_word = base ^ 16'h4C3A; mag_word = base ^ 16'hF00F;
    phs_word = base ^ 16'h1234; frq_word = base ^ 16'hA5A5; agc_word = base ^ 16'h0FF0;
    ter_word = base ^ 16'h6E91;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R1 watchdog [%s]: actual hung expected chain complete", case_tag);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0;
    set_words(16'h0000);
    link_after_i = 3'd7; link_tbl = '1; rate_sel = 3'b011;
    sync_inv = 1'b0; clk_pol = 1'b0; sync_early = 1'b0; tag_mode = 2'b00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check1("R12", "reset ser_clk",  ser_clk,  1'b0);
    check1("R12", "reset ser_data", ser_data, 1'b0);
    check1("R12", "reset ser_sync", ser_sync, 1'b0);

    case_tag = "R1 R2 R9 full ordered chain, early sync, rate /2";
    set_words(16'h3C5A);
    link_after_i = 3'd1;
    link_tbl = {3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    rate_sel = 3'b011; clk_pol = 1'b1; sync_inv = 1'b0; sync_early = 1'b1; tag_mode = 2'b00;
    kick(); wait_idle();

    case_tag = "R2 R4 R6 R7 R8 late sync, inverted sync, rate /16, tag 0";
    set_words(16'hC3A5);
    link_after_i = 3'd5;
    link_tbl = {3'd7, 3'd7, 3'd7, 3'd7, 3'd6, 3'd7};
    rate_sel = 3'b000; clk_pol = 1'b0; sync_inv = 1'b1; sync_early = 1'b0; tag_mode = 2'b01;
    kick(); wait_idle();

    case_tag = "R3 R4 R5 loop capped at seven words, full rate, tag 1";
    set_words(16'h0F1E);
    link_after_i = 3'd1;
    link_tbl = {3'd0, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7};
    rate_sel = 3'b110; clk_pol = 1'b1; sync_inv = 1'b0; sync_early = 1'b0; tag_mode = 2'b10;
    kick(); wait_idle();

    case_tag = "R3 R8 single I word, rate /4, tag 1x";
    set_words(16'h7FFE);
    link_after_i = 3'd7;
    rate_sel = 3'b010; clk_pol = 1'b0; sync_inv = 1'b0; sync_early = 1'b1; tag_mode = 2'b11;
    kick(); wait_idle();

    case_tag = "R10 R11 mid-chain input changes and start ignored, rate /8";
    set_words(16'h5AA5);
    link_after_i = 3'd2;
    link_tbl = {3'd7, 3'd4, 3'd7, 3'd0, 3'd7, 3'd7};
    rate_sel = 3'b001; clk_pol = 1'b1; sync_inv = 1'b1; sync_early = 1'b1; tag_mode = 2'b00;
    kick();
    repeat (40) @(negedge clk);
    set_words(16'hFFFF);
    link_after_i = 3'd7; rate_sel = 3'b110; clk_pol = 1'b0; sync_inv = 1'b0;
    sync_early = 1'b0; tag_mode = 2'b10;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (100) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_idle();

    case_tag = "R11 new configuration taken at next start";
    kick(); wait_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule